// File: doc/BRIEF.md
# DMA Controller Register Front-End

This block is the processor-side register file of a four-channel DMA controller. Software reaches it through a 4-bit byte-wide I/O port: a strobe-qualified offset, an 8-bit write bus and an 8-bit read bus. Each channel keeps a base and a current 16-bit address and a base and a current 16-bit count. Because the bus is only one byte wide, each 16-bit register sits behind a single offset. One shared byte pointer chooses whether an access reaches the low or the high byte. The pointer flips after every address or count access, and software can force it back to the low byte.

The block also holds a per-channel mode and mask, one command byte, per-channel software requests and terminal-count flags. It drives mode, mask and base values to a transfer engine. The engine returns updated current address and count values, together with terminal-count pulses. On a terminal count, a channel set to auto-initialize copies its base registers back into its current registers. Bus arbitration and memory cycles belong to the engine and are not part of this block.

Top module: `dmac_regfile`

## Requirements
- R1: After reset all four channel masks are 1 (masked), the byte pointer selects the low byte, and the command byte, request bits and terminal-count flags are 0.
- R2: A write to offset 2n (n = 0..3) stores one byte of channel n's address. The byte pointer chooses which: low byte when it is 0, high byte when it is 1. The byte goes into both the base and the current address, and a read of the same offset returns the current address byte that the pointer selects.
- R3: Offset 2n+1 behaves the same way for channel n's count, which holds the number of transfers minus one. A read returns the current count byte that the pointer selects.
- R4: A write of any value to offset 0xC returns the byte pointer to the low byte.
- R5: Every read or write at offsets 0x0 to 0x7 toggles the byte pointer.
- R6: A write to offset 0xA uses data bits 1:0 as the channel number. Data bit 2 = 1 masks that channel and bit 2 = 0 unmasks it. The other channels do not change.
- R7: A write to offset 0xF loads data bits 3:0 as the masks of channels 3..0. A write of any value to offset 0xE unmasks all four channels.
- R8: A write to offset 0xB uses data bits 1:0 as the channel number and stores data bits 7:2 as that channel's 6-bit mode. Mode bit 2 (data bit 4) means auto-initialize.
- R9: A write to offset 0x8 loads the command byte. A write to offset 0x9 uses data bits 1:0 as the channel number; data bit 2 sets or clears that channel's request bit.
- R10: An engine update pulse (eng_upd with eng_ch) loads the selected channel's current address and count from eng_addr and eng_cnt. The base registers do not change.
- R11: A read of offset 0x8 returns {request bits 3..0, terminal-count flags 3..0} and clears the flags. An eng_tc pulse sets the flag for its channel, and a new pulse in the same cycle as a status read wins.
- R12: On an eng_tc pulse, a channel with auto-initialize set reloads its current address and count from its base registers. A channel without it keeps the values the engine last wrote.
- R13: A write of any value to offset 0xD masks all channels and clears the byte pointer, the command byte, the request bits and the terminal-count flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 4 | Register offset |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Read data, combinational from offset and state |
| eng_upd | input | 1 | Engine writes current address and count |
| eng_ch | input | 2 | Channel for eng_upd |
| eng_addr | input | 16 | Current address from engine |
| eng_cnt | input | 16 | Current count from engine |
| eng_tc | input | 4 | Terminal-count pulse per channel |
| ch_mask | output | 4 | Channel masks, bit n for channel n |
| ch_mode | output | 24 | Six mode bits per channel, channel n at [6n+5:6n] |
| ch_base_addr | output | 64 | Base address per channel, channel n at [16n+15:16n] |
| ch_base_cnt | output | 64 | Base count per channel, channel n at [16n+15:16n] |
| cmd_out | output | 8 | Command byte |
| req_out | output | 4 | Software request bits |

## Verification
If the byte pointer ends up in the wrong state, the next two-byte access swaps its bytes. That shows up on the very next read-back of an address or count port, so the bench reads every 16-bit value back after each pointer operation, including after reads alone. An error in the auto-initialize or terminal-count logic shows up on the first count read or status read after the pulse. The bench therefore reads both right after each pulse, with and without auto-initialize, and reads status twice to confirm that the flags clear.

// File: rtl/dmac_regfile.sv
module dmac_regfile #(
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      io_addr,
  input  logic [7:0]      io_wdata,
  input  logic            io_wr,
  input  logic            io_rd,
  output logic [7:0]      io_rdata,
  input  logic            eng_upd,
  input  logic [1:0]      eng_ch,
  input  logic [AW-1:0]   eng_addr,
  input  logic [AW-1:0]   eng_cnt,
  input  logic [3:0]      eng_tc,
  output logic [3:0]      ch_mask,
  output logic [23:0]     ch_mode,
  output logic [4*AW-1:0] ch_base_addr,
  output logic [4*AW-1:0] ch_base_cnt,
  output logic [7:0]      cmd_out,
  output logic [3:0]      req_out
);
  localparam int NCH = 4;

  logic [AW-1:0] base_a [NCH];
  logic [AW-1:0] cur_a  [NCH];
  logic [AW-1:0] base_c [NCH];
  logic [AW-1:0] cur_c  [NCH];
  logic [5:0]    mode   [NCH];
  logic [3:0]    mask, req, tcf;
  logic [7:0]    cmd;
  logic          ptr;

  wire       is_chan  = ~io_addr[3];
  wire [1:0] sel      = io_addr[2:1];
  wire       is_cnt   = io_addr[0];
  wire       mclr     = io_wr && io_addr == 4'hD;
  wire       clr_ptr  = io_wr && io_addr == 4'hC;
  wire       rd_stat  = io_rd && io_addr == 4'h8;
  wire [1:0] wch      = io_wdata[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        base_a[i] <= '0; cur_a[i] <= '0;
        base_c[i] <= '0; cur_c[i] <= '0;
        mode[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (eng_upd && eng_ch == 2'(i)) begin
          cur_a[i] <= eng_addr;
          cur_c[i] <= eng_cnt;
        end
        if (eng_tc[i] && mode[i][2]) begin
          cur_a[i] <= base_a[i];
          cur_c[i] <= base_c[i];
        end
        if (io_wr && is_chan && sel == 2'(i)) begin
          if (!is_cnt) begin
            if (ptr) begin base_a[i][15:8] <= io_wdata; cur_a[i][15:8] <= io_wdata; end
            else     begin base_a[i][7:0]  <= io_wdata; cur_a[i][7:0]  <= io_wdata; end
          end else begin
            if (ptr) begin base_c[i][15:8] <= io_wdata; cur_c[i][15:8] <= io_wdata; end
            else     begin base_c[i][7:0]  <= io_wdata; cur_c[i][7:0]  <= io_wdata; end
          end
        end
        if (io_wr && io_addr == 4'hB && wch == 2'(i))
          mode[i] <= io_wdata[7:2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= 4'hF; req <= '0; tcf <= '0; cmd <= '0; ptr <= 1'b0;
    end else if (mclr) begin
      mask <= 4'hF; req <= '0; tcf <= '0; cmd <= '0; ptr <= 1'b0;
    end else begin
      if (clr_ptr)                     ptr <= 1'b0;
      else if ((io_rd || io_wr) && is_chan) ptr <= ~ptr;
      if (io_wr && io_addr == 4'hA) mask[wch] <= io_wdata[2];
      if (io_wr && io_addr == 4'hE) mask <= 4'h0;
      if (io_wr && io_addr == 4'hF) mask <= io_wdata[3:0];
      if (io_wr && io_addr == 4'h9) req[wch] <= io_wdata[2];
      if (io_wr && io_addr == 4'h8) cmd <= io_wdata;
      tcf <= (rd_stat ? 4'h0 : tcf) | eng_tc;
    end
  end

  always_comb begin
    io_rdata = 8'h00;
    if (is_chan) begin
      if (is_cnt) io_rdata = ptr ? cur_c[sel][15:8] : cur_c[sel][7:0];
      else        io_rdata = ptr ? cur_a[sel][15:8] : cur_a[sel][7:0];
    end else if (io_addr == 4'h8) begin
      io_rdata = {req, tcf};
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign ch_mode[6*g +: 6]       = mode[g];
    assign ch_base_addr[AW*g +: AW] = base_a[g];
    assign ch_base_cnt[AW*g +: AW]  = base_c[g];
  end
  assign ch_mask = mask;
  assign cmd_out = cmd;
  assign req_out = req;

  a_r4_ptr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ptr |=> !ptr);

  a_r5_ptr_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_rd || io_wr) && is_chan && !mclr) |=> ptr != $past(ptr));

  a_r13_master_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (ch_mask == 4'hF && !ptr && cmd_out == 8'h00 && req_out == 4'h0));

  a_r11_tc_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((|eng_tc) && !mclr) |=> ((io_rdata & 8'h0) == 8'h0) && ((tcf & $past(eng_tc)) == $past(eng_tc)));

  a_r8_mode_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 4'hB) |=> ch_mode[6*$past(io_wdata[1:0]) +: 6] == $past(io_wdata[7:2]));

  a_r7_clear_all_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 4'hE) |=> ch_mask == 4'h0);
endmodule

// File: tb/sim_dmac_regfile.sv
module sim_dmac_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic        eng_upd = 1'b0;
  logic [1:0]  eng_ch = '0;
  logic [15:0] eng_addr = '0, eng_cnt = '0;
  logic [3:0]  eng_tc = '0;
  logic [3:0]  ch_mask;
  logic [23:0] ch_mode;
  logic [63:0] ch_base_addr, ch_base_cnt;
  logic [7:0]  cmd_out;
  logic [3:0]  req_out;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  dmac_regfile u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    wr(a, v[7:0]); wr(a, v[15:8]);
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a, hi); v = {hi, lo};
  endtask

  task automatic upd(input logic [1:0] ch, input logic [15:0] a, input logic [15:0] c);
    @(negedge clk); eng_upd = 1'b1; eng_ch = ch; eng_addr = a; eng_cnt = c;
    @(negedge clk); eng_upd = 1'b0;
  endtask

  task automatic tc(input logic [3:0] m);
    @(negedge clk); eng_tc = m;
    @(negedge clk); eng_tc = '0;
  endtask

  task automatic t_reset;
    logic [7:0] s;
    chk("R1 mask", ch_mask, 4'hF);
    chk("R1 cmd", cmd_out, 8'h00);
    chk("R1 req", req_out, 4'h0);
    rd(4'h8, s);
    chk("R1 status", s, 8'h00);
  endtask

  task automatic t_addr_cnt;
    logic [15:0] v;
    wr(4'hC, 8'h00);
    for (int i = 0; i < 4; i++) begin
      wr16(4'(2*i), 16'hA100 + 16'(i * 16'h0123));
      wr16(4'(2*i+1), 16'h0F00 + 16'(i));
    end
    for (int i = 0; i < 4; i++) begin
      rd16(4'(2*i), v);
      chk("R2 addr readback", v, 16'hA100 + 16'(i * 16'h0123));
      chk("R2 base addr", ch_base_addr[16*i +: 16], 16'hA100 + 16'(i * 16'h0123));
      rd16(4'(2*i+1), v);
      chk("R3 count readback", v, 16'h0F00 + 16'(i));
      chk("R3 base count", ch_base_cnt[16*i +: 16], 16'h0F00 + 16'(i));
    end
  endtask

  task automatic t_ptr;
    logic [7:0] b;
    logic [15:0] v;
    wr(4'h0, 8'h55);
    wr(4'hC, 8'h7E);
    rd(4'h0, b);
    chk("R4 low byte after clear", b, 8'h55);
    wr(4'h0, 8'hC3);
    wr(4'hC, 8'h00);
    rd16(4'h0, v);
    chk("R5 read toggled pointer", v, 16'hC355);
  endtask

  task automatic t_mask;
    wr(4'hE, 8'h00);
    chk("R7 clear all masks", ch_mask, 4'h0);
    wr(4'hA, 8'h06);
    chk("R6 mask ch2", ch_mask, 4'h4);
    wr(4'hA, 8'h05);
    chk("R6 mask ch1", ch_mask, 4'h6);
    wr(4'hA, 8'h02);
    chk("R6 unmask ch2", ch_mask, 4'h2);
    wr(4'hF, 8'hF9);
    chk("R7 mask all", ch_mask, 4'h9);
  endtask

  task automatic t_mode_cmd_req;
    logic [7:0] s;
    wr(4'hB, 8'h55);
    wr(4'hB, 8'h4A);
    wr(4'hB, 8'hC3);
    chk("R8 mode ch1", ch_mode[11:6], 6'h15);
    chk("R8 mode ch2", ch_mode[17:12], 6'h12);
    chk("R8 mode ch3", ch_mode[23:18], 6'h30);
    chk("R8 mode ch0", ch_mode[5:0], 6'h00);
    wr(4'h8, 8'hA5);
    chk("R9 command", cmd_out, 8'hA5);
    wr(4'h9, 8'h07);
    wr(4'h9, 8'h04);
    wr(4'h9, 8'h03);
    chk("R9 request", req_out, 4'h1);
    rd(4'h8, s);
    chk("R9 status request bits", s, 8'h10);
  endtask

  task automatic t_engine;
    logic [15:0] v;
    logic [7:0] s;
    wr(4'hC, 8'h00);
    upd(2'd1, 16'h9999, 16'hFFFF);
    upd(2'd2, 16'h7777, 16'hFFFF);
    rd16(4'h2, v);
    chk("R10 current addr ch1", v, 16'h9999);
    chk("R10 base unchanged ch1", ch_base_addr[31:16], 16'hA223);
    tc(4'b0110);
    rd16(4'h2, v);
    chk("R12 autoinit addr ch1", v, 16'hA223);
    rd16(4'h3, v);
    chk("R12 autoinit count ch1", v, 16'h0F01);
    rd16(4'h5, v);
    chk("R12 no autoinit count ch2", v, 16'hFFFF);
    rd(4'h8, s);
    chk("R11 status tc flags", s, 8'h16);
    rd(4'h8, s);
    chk("R11 flags cleared", s, 8'h10);
    @(negedge clk); io_addr = 4'h8; io_rd = 1'b1; eng_tc = 4'b1000;
    @(negedge clk); io_rd = 1'b0; eng_tc = '0;
    rd(4'h8, s);
    chk("R11 new tc wins over clear", s, 8'h18);
  endtask

  task automatic t_mclr;
    logic [7:0] s, b;
    wr(4'hE, 8'h00);
    tc(4'b0001);
    wr(4'h0, 8'h11);
    wr(4'hD, 8'h00);
    chk("R13 masks set", ch_mask, 4'hF);
    chk("R13 cmd cleared", cmd_out, 8'h00);
    chk("R13 req cleared", req_out, 4'h0);
    rd(4'h8, s);
    chk("R13 status cleared", s, 8'h00);
    rd(4'h0, b);
    chk("R13 pointer low", b, 8'h11);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_addr_cnt;
        t_ptr;
        t_mask;
        t_mode_cmd_req;
        t_engine;
        t_mclr;
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule